// File: doc/BRIEF.md
# Telephony Audio Gain, Mute and Echo-Guard Datapath

This block sits between an 8 kHz narrowband codec stream of 8-bit µ-law bytes and a host-side stream of 16-bit linear PCM samples. In the record direction each incoming µ-law byte is expanded to linear PCM, scaled by a coarse power-of-two gain chosen from a 16-bit signed volume setting, and forced to zero while the record mute is set. In the playback direction each linear sample is scaled by its own gain, forced to silence while the playback mute is set, and compressed to a µ-law byte.

An echo guard compares the magnitude of every expanded record sample, taken before gain and mute, with a programmable 15-bit reference. While the guard is enabled and the last record sample was above the reference, playback is forced to silence. The comparison result can also be shown on a status output pin, with optional inversion. A small write-only register port loads the volumes, mutes, reference and control bits. Framing of the serial slot and the host transport are handled outside the block.

Top module: `tel_audio_path`

## Requirements
- R1: After reset both valid outputs and `guard_pin` are low, the record volume is 0xF600, the playback volume is 0xD800 (both unity gain), both mutes are zero, the reference is 0x5800 and all control bits are zero.
- R2: A record byte presented with `rec_valid` appears as linear PCM on `rec_pcm` with `rec_pcm_valid` high one clock later; with the code inverted, bit 7 of the inverted code is the sign (1 = negative), bits 6:4 the segment e and bits 3:0 the step m, and the magnitude is ((8m+132)<<e)-132. Between samples `rec_pcm` holds its value and `rec_pcm_valid` is low.
- R3: The record gain decodes the volume (register 0) as a signed 16-bit value: 0xFE00 and above, and all of 0x0000..0x7FFF, give ×4; 0xFB00..0xFDFF ×2; 0xF200..0xFAFF ×1; 0xD800..0xF1FF ÷2; 0x8000..0xD7FF ÷4.
- R4: The playback gain decodes register 1 the same way with bands ×4 from 0xFB00 (and all positive values), ×2 from 0xE700, ×1 from 0xC900, ÷2 from 0xA200, ÷4 below; the scaled sample is compressed with the segment encoding of R2 (magnitude clipped to 32635, bias 132, code inverted) and appears on `ply_ulaw` with `ply_ulaw_valid` one clock after `ply_valid`.
- R5: Multiplying gains saturate to 0x7FFF or 0x8000 rather than wrapping.
- R6: Dividing gains are arithmetic right shifts, so results round toward minus infinity (-3 ÷4 gives -1).
- R7: Any nonzero value in the record mute (register 2, bits 7:0) makes `rec_pcm` zero; any nonzero value in the playback mute (register 3) makes `ply_ulaw` 0xFF.
- R8: With control bit 0 set, a playback sample presented after a record sample whose magnitude exceeded the reference yields 0xFF; the first later record sample whose magnitude is not above the reference releases it. A record and a playback sample in the same cycle use the earlier comparison.
- R9: Control bit 1 selects the magnitude: 0 takes the absolute value of the two's-complement sample, 1 takes bits 14:0 as a sign-magnitude value.
- R10: `guard_pin` is the comparison result when control bit 2 is set, inverted when control bit 3 is also set, and low when bit 2 is clear; the comparison runs whether or not bit 0 is set.
- R11: The reference (register 4) takes bits 14:0 of the write data; writes to addresses 6 and 7 change nothing.
- R12: The echo-guard comparison uses the expanded sample before record gain and mute, so neither affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (0 rec vol, 1 play vol, 2 rec mute, 3 play mute, 4 reference, 5 control) |
| cfg_wdata | input | 16 | Register write data |
| rec_valid | input | 1 | Record µ-law byte present |
| rec_ulaw | input | 8 | Record µ-law byte |
| rec_pcm_valid | output | 1 | Record PCM sample present |
| rec_pcm | output | 16 | Record PCM sample, two's complement |
| ply_valid | input | 1 | Playback PCM sample present |
| ply_pcm | input | 16 | Playback PCM sample, two's complement |
| ply_ulaw_valid | output | 1 | Playback µ-law byte present |
| ply_ulaw | output | 8 | Playback µ-law byte |
| guard_pin | output | 1 | Echo-guard comparison status |

## Verification
The hardest states to reach are the band edges of the two volume decoders and the cases where a gain step would overflow, since random 16-bit volumes land almost entirely in the two ÷4 bands and positive ×4. The stimulus draws volumes from a mix of exact band boundaries, one-below-boundary values and random values, and draws record codes biased toward the top segment so that ×2 and ×4 reach saturation. The guard release is reached by alternating loud and quiet record codes against a random reference, with playback samples interleaved between them, and the sign-magnitude format is exercised with small negative samples whose low 15 bits are large.

// File: rtl/tap_pkg.sv
package tap_pkg;

   // register addresses
   localparam int REG_REC_VOL  = 0;
   localparam int REG_PLY_VOL  = 1;
   localparam int REG_REC_MUTE = 2;
   localparam int REG_PLY_MUTE = 3;
   localparam int REG_REF      = 4;
   localparam int REG_CTRL     = 5;

   // control bit positions
   localparam int CTL_GUARD   = 0;
   localparam int CTL_SIGNMAG = 1;
   localparam int CTL_PIN_EN  = 2;
   localparam int CTL_PIN_INV = 3;
   localparam int CTL_W       = 4;

   // gain levels, unity in the middle
   localparam int GAIN_STEPS = 2;
   localparam int LVL_W      = 3;

   typedef enum logic [LVL_W-1:0] {
      G_DIV4  = 3'd0,
      G_DIV2  = 3'd1,
      G_UNITY = 3'd2,
      G_MUL2  = 3'd3,
      G_MUL4  = 3'd4
   } gain_e;

   localparam logic [15:0] ULAW_BIAS = 16'd132;
   localparam logic [15:0] ULAW_CLIP = 16'd32635;

   function automatic logic signed [15:0] ulaw_expand(input logic [7:0] code);
      logic [7:0]  u;
      logic [15:0] t;
      logic signed [15:0] v;
      u = ~code;
      t = ({9'b0, u[3:0], 3'b000} + ULAW_BIAS) << u[6:4];
      v = $signed(t - ULAW_BIAS);
      return u[7] ? -v : v;
   endfunction

   function automatic logic [7:0] ulaw_compress(input logic signed [15:0] x);
      logic        sgn;
      logic [15:0] mag;
      logic [15:0] b;
      logic [15:0] tmp;
      logic [2:0]  ex;
      sgn = x[15];
      mag = sgn ? 16'(-x) : 16'(x);
      if (mag > ULAW_CLIP) mag = ULAW_CLIP;
      b  = mag + ULAW_BIAS;
      ex = 3'd0;
      for (int i = 0; i < 8; i++) begin
         if (b[i+7]) ex = 3'(i);
      end
      tmp = b >> ({1'b0, ex} + 4'd3);
      return ~{sgn, ex, tmp[3:0]};
   endfunction

endpackage

// File: rtl/tap_gain_decode.sv
module tap_gain_decode
   import tap_pkg::*;
#(
   parameter int             VOL_W = 16,
   parameter logic [VOL_W-1:0] TH_X4 = 16'hFE00,
   parameter logic [VOL_W-1:0] TH_X2 = 16'hFB00,
   parameter logic [VOL_W-1:0] TH_X1 = 16'hF200,
   parameter logic [VOL_W-1:0] TH_D2 = 16'hD800
) (
   input  logic [VOL_W-1:0] vol,
   output gain_e            lvl
);

   if (!($signed(TH_X4) > $signed(TH_X2) && $signed(TH_X2) > $signed(TH_X1)
         && $signed(TH_X1) > $signed(TH_D2))) begin : g_bad_order
      $error("gain thresholds must descend");
   end

   always_comb begin
      if ($signed(vol) >= $signed(TH_X4))      lvl = G_MUL4;
      else if ($signed(vol) >= $signed(TH_X2)) lvl = G_MUL2;
      else if ($signed(vol) >= $signed(TH_X1)) lvl = G_UNITY;
      else if ($signed(vol) >= $signed(TH_D2)) lvl = G_DIV2;
      else                                     lvl = G_DIV4;
   end

endmodule

// File: rtl/tap_sat_shift.sv
module tap_sat_shift
   import tap_pkg::*;
#(
   parameter int W         = 16,
   parameter int MAX_SHIFT = GAIN_STEPS
) (
   input  logic signed [W-1:0] x,
   input  logic [LVL_W-1:0]    lvl,
   output logic signed [W-1:0] y
);

   localparam logic signed [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic signed [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

   if (MAX_SHIFT < 1 || MAX_SHIFT >= W - 1) begin : g_bad_shift
      $error("shift range out of bounds");
   end
   if (2 * MAX_SHIFT >= (1 << LVL_W)) begin : g_bad_lvl
      $error("level field too narrow");
   end

   logic signed [W-1:0] up_c [0:MAX_SHIFT];
   logic signed [W-1:0] dn_c [0:MAX_SHIFT];

   assign up_c[0] = x;
   assign dn_c[0] = x;

   for (genvar k = 1; k <= MAX_SHIFT; k++) begin : g_step
      logic ovf;
      assign ovf     = (x[W-1:W-1-k] != {(k+1){x[W-1]}});
      assign up_c[k] = ovf ? (x[W-1] ? NEG_MAX : POS_MAX) : (x <<< k);
      assign dn_c[k] = x >>> k;
   end

   always_comb begin
      y = x;
      for (int i = 0; i <= MAX_SHIFT; i++) begin
         if (lvl == LVL_W'(MAX_SHIFT + i)) y = up_c[i];
         if (lvl == LVL_W'(MAX_SHIFT - i)) y = dn_c[i];
      end
   end

endmodule

// File: rtl/tap_echo_guard.sv
module tap_echo_guard #(
   parameter int PCM_W = 16,
   parameter int REF_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [PCM_W-1:0] smp,
   input  logic             signmag,
   input  logic [REF_W-1:0] ref_lvl,
   output logic             over_q
);

   if (REF_W >= PCM_W) begin : g_bad_ref
      $error("reference must be narrower than the sample");
   end

   logic [PCM_W-1:0] mag;
   logic [PCM_W-1:0] ref_ext;

   assign ref_ext = {{(PCM_W-REF_W){1'b0}}, ref_lvl};

   always_comb begin
      if (signmag) mag = {1'b0, smp[PCM_W-2:0]};
      else         mag = smp[PCM_W-1] ? (~smp + 1'b1) : smp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         over_q <= 1'b0;
      else if (smp_valid) over_q <= (mag > ref_ext);
   end

endmodule

// File: rtl/tel_audio_path.sv
module tel_audio_path
   import tap_pkg::*;
#(
   parameter int PCM_W  = 16,
   parameter int CODE_W = 8,
   parameter int VOL_W  = 16,
   parameter int MUTE_W = 8,
   parameter int REF_W  = 15,
   parameter int ADDR_W = 3,
   parameter int CFG_W  = 16,
   parameter logic [VOL_W-1:0] REC_VOL_RST = 16'hF600,
   parameter logic [VOL_W-1:0] PLY_VOL_RST = 16'hD800,
   parameter logic [REF_W-1:0] REF_RST     = 15'h5800,
   parameter logic [VOL_W-1:0] REC_TH_X4   = 16'hFE00,
   parameter logic [VOL_W-1:0] REC_TH_X2   = 16'hFB00,
   parameter logic [VOL_W-1:0] REC_TH_X1   = 16'hF200,
   parameter logic [VOL_W-1:0] REC_TH_D2   = 16'hD800,
   parameter logic [VOL_W-1:0] PLY_TH_X4   = 16'hFB00,
   parameter logic [VOL_W-1:0] PLY_TH_X2   = 16'hE700,
   parameter logic [VOL_W-1:0] PLY_TH_X1   = 16'hC900,
   parameter logic [VOL_W-1:0] PLY_TH_D2   = 16'hA200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              rec_valid,
   input  logic [CODE_W-1:0] rec_ulaw,
   output logic              rec_pcm_valid,
   output logic [PCM_W-1:0]  rec_pcm,
   input  logic              ply_valid,
   input  logic [PCM_W-1:0]  ply_pcm,
   output logic              ply_ulaw_valid,
   output logic [CODE_W-1:0] ply_ulaw,
   output logic              guard_pin
);

   if (PCM_W != 16 || CODE_W != 8) begin : g_bad_fmt
      $error("companding is defined for 16-bit PCM and 8-bit codes");
   end
   if (CFG_W < VOL_W || CFG_W < MUTE_W || CFG_W < REF_W || CFG_W < CTL_W) begin : g_bad_cfg
      $error("write data narrower than a register");
   end
   if ((1 << ADDR_W) <= REG_CTRL) begin : g_bad_addr
      $error("address field too narrow for the register set");
   end

   localparam logic [CODE_W-1:0] SILENCE = 8'hFF;

   // configuration state
   logic [VOL_W-1:0]  rec_vol_q, ply_vol_q;
   logic [MUTE_W-1:0] rec_mute_q, ply_mute_q;
   logic [REF_W-1:0]  ref_q;
   logic [CTL_W-1:0]  ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_vol_q  <= REC_VOL_RST;
         ply_vol_q  <= PLY_VOL_RST;
         rec_mute_q <= '0;
         ply_mute_q <= '0;
         ref_q      <= REF_RST;
         ctrl_q     <= '0;
      end else if (cfg_we) begin
         if (cfg_addr == ADDR_W'(REG_REC_VOL))  rec_vol_q  <= cfg_wdata[VOL_W-1:0];
         if (cfg_addr == ADDR_W'(REG_PLY_VOL))  ply_vol_q  <= cfg_wdata[VOL_W-1:0];
         if (cfg_addr == ADDR_W'(REG_REC_MUTE)) rec_mute_q <= cfg_wdata[MUTE_W-1:0];
         if (cfg_addr == ADDR_W'(REG_PLY_MUTE)) ply_mute_q <= cfg_wdata[MUTE_W-1:0];
         if (cfg_addr == ADDR_W'(REG_REF))      ref_q      <= cfg_wdata[REF_W-1:0];
         if (cfg_addr == ADDR_W'(REG_CTRL))     ctrl_q     <= cfg_wdata[CTL_W-1:0];
      end
   end

   // gain selection
   gain_e rec_lvl, ply_lvl;

   tap_gain_decode #(
      .VOL_W(VOL_W), .TH_X4(REC_TH_X4), .TH_X2(REC_TH_X2),
      .TH_X1(REC_TH_X1), .TH_D2(REC_TH_D2)
   ) u_rec_dec (
      .vol(rec_vol_q),
      .lvl(rec_lvl)
   );

   tap_gain_decode #(
      .VOL_W(VOL_W), .TH_X4(PLY_TH_X4), .TH_X2(PLY_TH_X2),
      .TH_X1(PLY_TH_X1), .TH_D2(PLY_TH_D2)
   ) u_ply_dec (
      .vol(ply_vol_q),
      .lvl(ply_lvl)
   );

   // record path: expand, scale, mute
   logic signed [PCM_W-1:0] rec_lin, rec_scaled;
   assign rec_lin = ulaw_expand(rec_ulaw);

   tap_sat_shift #(.W(PCM_W), .MAX_SHIFT(GAIN_STEPS)) u_rec_shift (
      .x  (rec_lin),
      .lvl(rec_lvl),
      .y  (rec_scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rec_pcm_valid <= 1'b0;
         rec_pcm       <= '0;
      end else begin
         rec_pcm_valid <= rec_valid;
         if (rec_valid) rec_pcm <= (|rec_mute_q) ? '0 : rec_scaled;
      end
   end

   // echo guard on the unscaled record sample
   logic over_q;

   tap_echo_guard #(.PCM_W(PCM_W), .REF_W(REF_W)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_valid(rec_valid),
      .smp      (rec_lin),
      .signmag  (ctrl_q[CTL_SIGNMAG]),
      .ref_lvl  (ref_q),
      .over_q   (over_q)
   );

   assign guard_pin = ctrl_q[CTL_PIN_EN] & (over_q ^ ctrl_q[CTL_PIN_INV]);

   // playback path: scale, mute, compress
   logic signed [PCM_W-1:0] ply_scaled;
   logic                    ply_silent;

   tap_sat_shift #(.W(PCM_W), .MAX_SHIFT(GAIN_STEPS)) u_ply_shift (
      .x  (ply_pcm),
      .lvl(ply_lvl),
      .y  (ply_scaled)
   );

   assign ply_silent = (|ply_mute_q) | (ctrl_q[CTL_GUARD] & over_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ply_ulaw_valid <= 1'b0;
         ply_ulaw       <= SILENCE;
      end else begin
         ply_ulaw_valid <= ply_valid;
         if (ply_valid) ply_ulaw <= ply_silent ? SILENCE : ulaw_compress(ply_scaled);
      end
   end

endmodule

// File: rtl/tap_checker.sv
module tap_checker #(
   parameter int PCM_W  = 16,
   parameter int CODE_W = 8,
   parameter int MUTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rec_valid,
   input logic              rec_pcm_valid,
   input logic [PCM_W-1:0]  rec_pcm,
   input logic              ply_valid,
   input logic              ply_ulaw_valid,
   input logic [CODE_W-1:0] ply_ulaw,
   input logic [MUTE_W-1:0] rec_mute,
   input logic [MUTE_W-1:0] ply_mute,
   input logic              guard_en,
   input logic              over
);

   AST_REC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |=> rec_pcm_valid); // R2

   AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rec_valid |=> (!rec_pcm_valid && $stable(rec_pcm))); // R2

   AST_PLY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      ply_valid |=> ply_ulaw_valid); // R4

   AST_REC_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && rec_mute != '0) |=> (rec_pcm == '0)); // R7

   AST_PLY_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ply_valid && ply_mute != '0) |=> (ply_ulaw == 8'hFF)); // R7

   AST_GUARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ply_valid && guard_en && over) |=> (ply_ulaw == 8'hFF)); // R8

endmodule

bind tel_audio_path tap_checker #(.PCM_W(PCM_W), .CODE_W(CODE_W), .MUTE_W(MUTE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rec_valid     (rec_valid),
   .rec_pcm_valid (rec_pcm_valid),
   .rec_pcm       (rec_pcm),
   .ply_valid     (ply_valid),
   .ply_ulaw_valid(ply_ulaw_valid),
   .ply_ulaw      (ply_ulaw),
   .rec_mute      (rec_mute_q),
   .ply_mute      (ply_mute_q),
   .guard_en      (ctrl_q[0]),
   .over          (over_q)
);

// File: tb/tel_audio_path_tb.sv
module tel_audio_path_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        rec_valid = 1'b0;
   logic [7:0]  rec_ulaw = '0;
   logic        rec_pcm_valid;
   logic [15:0] rec_pcm;
   logic        ply_valid = 1'b0;
   logic [15:0] ply_pcm = '0;
   logic        ply_ulaw_valid;
   logic [7:0]  ply_ulaw;
   logic        guard_pin;

   always #(CLK_PERIOD/2) clk = ~clk;

   tel_audio_path u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .rec_valid(rec_valid), .rec_ulaw(rec_ulaw),
      .rec_pcm_valid(rec_pcm_valid), .rec_pcm(rec_pcm), .ply_valid(ply_valid),
      .ply_pcm(ply_pcm), .ply_ulaw_valid(ply_ulaw_valid), .ply_ulaw(ply_ulaw),
      .guard_pin(guard_pin)
   );

   int n_chk = 0;
   int n_fail = 0;

   // model state
   int m_rvol, m_pvol, m_rmute, m_pmute, m_ref, m_ctrl;
   bit m_over;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int to_s16(input int v);
      v = v & 16'hFFFF;
      return (v >= 32768) ? v - 65536 : v;
   endfunction

   function automatic int m_expand(input int code);
      int u, s, e, m, v;
      u = (~code) & 255;
      s = u >> 7;
      e = (u >> 4) & 7;
      m = u & 15;
      v = (((2 * m + 33) << e) - 33) * 4;
      return s ? -v : v;
   endfunction

   function automatic int m_compress(input int x);
      int s, a, e, mt;
      s = (x < 0) ? 1 : 0;
      a = s ? -x : x;
      if (a > 32635) a = 32635;
      a = a + 132;
      e = 0;
      for (int k = 1; k < 8; k++) if (a >= (128 << k)) e = k;
      mt = (a >> (e + 3)) & 15;
      return (~((s << 7) | (e << 4) | mt)) & 255;
   endfunction

   // shift amount: +2 .. -2
   function automatic int m_rec_sh(input int vol);
      int v;
      v = to_s16(vol);
      if (v >= -512)   return 2;
      if (v >= -1280)  return 1;
      if (v >= -3584)  return 0;
      if (v >= -10240) return -1;
      return -2;
   endfunction

   function automatic int m_ply_sh(input int vol);
      int v;
      v = to_s16(vol);
      if (v >= -1280)  return 2;
      if (v >= -6400)  return 1;
      if (v >= -14080) return 0;
      if (v >= -24064) return -1;
      return -2;
   endfunction

   function automatic int m_gain(input int x, input int sh);
      int y;
      if (sh >= 0) begin
         y = x * (1 << sh);
         if (y > 32767) y = 32767;
         if (y < -32768) y = -32768;
      end else begin
         y = x >>> (-sh);
      end
      return y;
   endfunction

   function automatic int m_mag(input int x, input int signmag);
      if (signmag != 0) return x & 32767;
      return (x < 0) ? -x : x;
   endfunction

   function automatic int m_pin();
      if (((m_ctrl >> 2) & 1) == 0) return 0;
      return int'(m_over) ^ ((m_ctrl >> 3) & 1);
   endfunction

   task automatic wr(input int a, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
      @(negedge clk);
      cfg_we = 1'b0;
      case (a)
         0: m_rvol  = d & 16'hFFFF;
         1: m_pvol  = d & 16'hFFFF;
         2: m_rmute = d & 8'hFF;
         3: m_pmute = d & 8'hFF;
         4: m_ref   = d & 15'h7FFF;
         5: m_ctrl  = d & 4'hF;
         default: ;
      endcase
   endtask

   task automatic rec_s(input int code, input string req);
      int lin, exp_v;
      @(negedge clk);
      rec_valid = 1'b1; rec_ulaw = 8'(code);
      @(negedge clk);
      rec_valid = 1'b0;
      lin = m_expand(code);
      exp_v = (m_rmute != 0) ? 0 : m_gain(lin, m_rec_sh(m_rvol));
      m_over = (m_mag(lin, (m_ctrl >> 1) & 1) > m_ref);
      chk({req, " rec valid"}, int'(rec_pcm_valid), 1);
      chk({req, " rec data"}, int'(rec_pcm), exp_v & 16'hFFFF);
      chk({req, " pin"}, int'(guard_pin), m_pin());
   endtask

   task automatic ply_s(input int x, input string req);
      int exp_c, y;
      @(negedge clk);
      ply_valid = 1'b1; ply_pcm = 16'(x);
      @(negedge clk);
      ply_valid = 1'b0;
      y = m_gain(to_s16(x), m_ply_sh(m_pvol));
      if (m_pmute != 0 || ((m_ctrl & 1) != 0 && m_over)) exp_c = 255;
      else exp_c = m_compress(y);
      chk({req, " ply valid"}, int'(ply_ulaw_valid), 1);
      chk({req, " ply data"}, int'(ply_ulaw), exp_c);
   endtask

   function automatic int pick_vol(input int r, input bit ply);
      int b;
      b = r % 8;
      if (ply) begin
         case (b)
            0: return 16'hFB00; 1: return 16'hE700; 2: return 16'hC900; 3: return 16'hA200;
            4: return (16'hFB00 - 1); 5: return (16'hC900 - 1); 6: return 16'h8000;
            default: return $urandom & 16'hFFFF;
         endcase
      end
      case (b)
         0: return 16'hFE00; 1: return 16'hFB00; 2: return 16'hF200; 3: return 16'hD800;
         4: return (16'hFB00 - 1); 5: return (16'hD800 - 1); 6: return 16'h0000;
         default: return $urandom & 16'hFFFF;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'd560);
      m_rvol = 16'hF600; m_pvol = 16'hD800; m_rmute = 0; m_pmute = 0;
      m_ref = 15'h5800; m_ctrl = 0; m_over = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rec valid idle", int'(rec_pcm_valid), 0);
      chk("R1 ply valid idle", int'(ply_ulaw_valid), 0);
      chk("R1 pin low", int'(guard_pin), 0);
      rst_n = 1'b1;
      // R1 default unity gains
      rec_s(8'hA5, "R1");
      ply_s(1000, "R1");
      ply_s(-7777, "R1");
      // R2 expansion corners
      rec_s(8'h00, "R2");
      rec_s(8'h80, "R2");
      rec_s(8'hFF, "R2");
      rec_s(8'h7F, "R2");
      rec_s(8'hF0, "R2");
      // R3 record bands at edges
      wr(0, 16'hFE00); rec_s(8'hC3, "R3 x4");
      wr(0, 16'hFDFF); rec_s(8'hC3, "R3 x2");
      wr(0, 16'hFB00); rec_s(8'h43, "R3 x2");
      wr(0, 16'hF200); rec_s(8'hC3, "R3 x1");
      wr(0, 16'hF1FF); rec_s(8'h43, "R3 d2");
      wr(0, 16'hD7FF); rec_s(8'hC3, "R3 d4");
      wr(0, 16'h1234); rec_s(8'hC3, "R3 positive");
      // R5 saturation
      wr(0, 16'h0000); rec_s(8'h80, "R5 pos sat"); rec_s(8'h00, "R5 neg sat");
      // R4 playback bands
      wr(1, 16'hFB00); ply_s(300, "R4 x4");
      wr(1, 16'hFAFF); ply_s(-300, "R4 x2");
      wr(1, 16'hC900); ply_s(300, "R4 x1");
      wr(1, 16'hC8FF); ply_s(300, "R4 d2");
      wr(1, 16'hA1FF); ply_s(-3, "R6 floor");
      wr(1, 16'h0100); ply_s(16'h7000, "R5 ply sat"); ply_s(-32768, "R5 ply neg");
      // R7 mutes
      wr(2, 16'h0100); rec_s(8'h90, "R7 upper bits ignored");
      wr(2, 16'h0040); rec_s(8'h90, "R7 rec mute");
      wr(3, 16'h0001); ply_s(5000, "R7 ply mute");
      wr(2, 0); wr(3, 0);
      // R8 echo guard and release
      wr(1, 16'hC900); wr(4, 1000); wr(5, 16'h0001);
      rec_s(8'h90, "R8 loud"); ply_s(2000, "R8 silenced"); ply_s(-2000, "R8 still silenced");
      rec_s(8'hFC, "R8 quiet"); ply_s(2000, "R8 released");
      // R12 comparison before gain and mute
      wr(0, 16'h8000); wr(2, 16'h00FF);
      rec_s(8'h90, "R12 loud while muted"); ply_s(2000, "R12 silenced");
      wr(2, 0); wr(0, 16'hF600);
      // R9 sign-magnitude view of a small negative sample
      rec_s(8'h7C, "R9 twos"); ply_s(2000, "R9 twos");
      wr(5, 16'h0003);
      rec_s(8'h7C, "R9 signmag"); ply_s(2000, "R9 signmag");
      // R10 pin
      wr(5, 16'h0006); rec_s(8'h7C, "R10 pin"); ply_s(2000, "R10 guard off");
      wr(5, 16'h000E); rec_s(8'h7C, "R10 pin inv");
      wr(5, 16'h0008); rec_s(8'h7C, "R10 pin disabled");
      // R11 ignored addresses, reference width
      wr(6, 16'hFFFF); wr(7, 16'h1234);
      rec_s(8'h93, "R11 no effect"); ply_s(1234, "R11 no effect");
      wr(4, 16'hFFFF); wr(5, 16'h0005); rec_s(8'h80, "R11 ref 15 bit");
      // random mix
      for (int it = 0; it < 600; it++) begin
         int r;
         r = $urandom;
         case (r % 6)
            0: wr(0, pick_vol($urandom, 1'b0));
            1: wr(1, pick_vol($urandom, 1'b1));
            2: wr(2, ((r >> 8) % 4 == 0) ? ($urandom & 255) : 0);
            3: wr(3, ((r >> 8) % 4 == 0) ? ($urandom & 255) : 0);
            4: wr(4, $urandom & 16'h7FFF);
            default: wr(5, $urandom & 15);
         endcase
         if ((r >> 12) % 2 == 0) rec_s(($urandom % 3 == 0) ? ($urandom & 8'h8F) : ($urandom & 255), "R3 random");
         ply_s($urandom & 16'hFFFF, "R4 random");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule